// File: doc/BRIEF.md
# Serial Control-Port Register File

This block is the configuration slave of a stereo converter. A host drives a serial clock, an active-low latch line and a serial command input. The block shifts in 16-bit command words and turns them into writes to three 10-bit control registers. It can also answer reads, shifting the requested register back out on a separate serial output. The control registers appear as parallel configuration outputs for the rest of the converter.

Two further registers follow the largest 6-bit magnitude seen on the left and right channels since they were last read. The sampling side feeds them through a shared valid strobe. A read is set up by one frame and its reply is shifted out during the next frame.

All serial inputs are oversampled in the system clock domain. They pass through a synchronizer of configurable depth, and serial clock edges are then detected from the synchronized level.

Top module: `ctl_port_regfile`

## Requirements
- R1: While `latch_n_i` is high, serial clock edges and data are ignored, and `sdo_o` is low once the latch level has crossed the synchronizer.
- R2: Command bits are taken most significant bit first, each on a rising serial clock edge. The 16-bit word is address in bits 15..12, a flag in bit 11 (1 = read, 0 = write), a reserved bit 10 and data in bits 9..0.
- R3: A write frame of exactly 16 bits to address 0, 1 or 2 loads its data into `cfg0_o`, `cfg1_o` or `cfg2_o` respectively when the latch line returns high.
- R4: A frame whose length is not exactly 16 bits changes no register and schedules no readback.
- R5: Writes to address 3, address 4 or any address from 5 to 15 change no register.
- R6: After a 16-bit read frame, the next frame shifts out the word {address, 1, 0, data}. Its MSB is present from the frame start, and the output moves to the next bit on each falling serial clock edge.
- R7: Address 3 reads back the left peak and address 4 the right peak, each zero-extended in bits 9..0. Addresses 5 to 15 read back zero data.
- R8: A frame that does not follow a 16-bit read frame shifts out only zeros.
- R9: When bit 0 of control register 2 is 1, each sample accepted with `smp_vld_i` raises a peak register to the sample if it is larger. When that bit is 0, the peak registers hold.
- R10: Reading a peak register clears it at the start of the reply frame. A sample accepted in that same cycle becomes the new stored value.
- R11: After reset all control registers and peak registers are zero and `sdo_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial port |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| latch_n_i | input | 1 | Active-low frame enable |
| sdi_i | input | 1 | Serial command data in |
| sdo_o | output | 1 | Serial readback data out |
| smp_vld_i | input | 1 | Both sample magnitudes are valid this cycle |
| smp_l_i | input | 6 | Left channel sample magnitude |
| smp_r_i | input | 6 | Right channel sample magnitude |
| cfg0_o | output | 10 | Control register 0 |
| cfg1_o | output | 10 | Control register 1 |
| cfg2_o | output | 10 | Control register 2 (bit 0 enables peak tracking) |

## Verification
The assertions assume the host keeps `latch_n_i` and `sclk_i` stable for longer than the synchronizer depth. Without that, edges could merge or be missed and the output-idle window would not be defined. The stimulus holds every serial level for at least three system clocks and changes inputs only on falling system clock edges. It changes `sdi_i` several cycles ahead of the rising serial edge that samples it. Sample strobes are single-cycle pulses. One of them is placed on purpose in the cycle where a clear-on-read takes effect.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 10;
    localparam int PEAK_W  = 6;
    localparam int NUM_CFG = 3;
    localparam int NUM_CH  = 2;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    // register that holds the tracking enable, and its bit
    localparam int TRK_REG = 2;
    localparam int TRK_BIT = 0;

    // first peak register address; channels follow in order
    localparam logic [ADDR_W-1:0] PEAK_BASE = ADDR_W'(3);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              rsvd;
        logic [DATA_W-1:0] data;
    } word_t;

endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int                 WIDTH  = 3,
    parameter int                 STAGES = 2,
    parameter logic [WIDTH-1:0]   INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{INIT}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign lvl = chain_q[STAGES-1];

endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
    import ctl_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              shift_en,
    input  logic              sdi,
    output logic              cmd_vld,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_rd,
    output logic [DATA_W-1:0] cmd_data
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.sh  = '0;
            s_d.cnt = '0;
        end else if (shift_en) begin
            s_d.sh = {s_q.sh[FRAME_W-2:0], sdi};
            if (s_q.cnt != CNT_OVER) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_vld  = stop && (s_q.cnt == CNT_FULL);
    assign cmd_addr = s_q.sh[FRAME_W-1 -: ADDR_W];
    assign cmd_rd   = s_q.sh[DATA_W+1];
    assign cmd_data = s_q.sh[DATA_W-1:0];

endmodule

// File: rtl/peak_track.sv
module peak_track #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         vld,
    input  logic [W-1:0] smp,
    input  logic         clr,
    output logic [W-1:0] peak
);

    logic [W-1:0] pk_d, pk_q;
    logic         take;

    always_comb begin
        take = en && vld;
        pk_d = pk_q;
        if (clr) begin
            pk_d = take ? smp : '0;
        end else if (take && (smp > pk_q)) begin
            pk_d = smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign peak = pk_q;

endmodule

// File: rtl/reply_tx.sv
module reply_tx
    import ctl_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  load,
    input  word_t word,
    input  logic  shift_en,
    input  logic  active,
    output logic  sdo
);

    logic [FRAME_W-1:0] tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (start) begin
            tx_d = load ? FRAME_W'(word) : '0;
        end else if (shift_en) begin
            tx_d = {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sdo = active & tx_q[FRAME_W-1];

endmodule

// File: rtl/ctl_port_regfile.sv
module ctl_port_regfile
    import ctl_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              latch_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    input  logic              smp_vld_i,
    input  logic [PEAK_W-1:0] smp_l_i,
    input  logic [PEAK_W-1:0] smp_r_i,
    output logic [DATA_W-1:0] cfg0_o,
    output logic [DATA_W-1:0] cfg1_o,
    output logic [DATA_W-1:0] cfg2_o
);

    // synchronized serial inputs: bit 0 clock, bit 1 latch, bit 2 data
    localparam int          SYNC_W    = 3;
    localparam logic [2:0]  SYNC_INIT = 3'b010;

    typedef struct packed {
        logic [NUM_CFG-1:0][DATA_W-1:0] cfg;
        logic                           rd_pend;
        logic [ADDR_W-1:0]              rd_addr;
        logic                           sclk_prev;
        logic                           lat_prev;
    } top_t;

    top_t s_d, s_q;

    logic [SYNC_W-1:0] sync_lvl;
    logic              sclk_s, lat_s, sdi_s;
    logic              active, lat_start, lat_stop;
    logic              sclk_rise, sclk_fall;

    logic              cmd_vld;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_rd;
    logic [DATA_W-1:0] cmd_data;

    logic [DATA_W-1:0] rd_data;
    word_t             reply;
    logic              trk_en;

    logic [NUM_CH-1:0]             pk_clr;
    logic [NUM_CH-1:0][PEAK_W-1:0] pk_smp;
    logic [NUM_CH-1:0][PEAK_W-1:0] pk_val;

    ser_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .INIT   (SYNC_INIT)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sdi_i, latch_n_i, sclk_i}),
        .lvl   (sync_lvl)
    );

    assign sclk_s    = sync_lvl[0];
    assign lat_s     = sync_lvl[1];
    assign sdi_s     = sync_lvl[2];
    assign active    = ~lat_s;
    assign lat_start = ~lat_s & s_q.lat_prev;
    assign lat_stop  = lat_s & ~s_q.lat_prev;
    assign sclk_rise = sclk_s & ~s_q.sclk_prev;
    assign sclk_fall = ~sclk_s & s_q.sclk_prev;

    cmd_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (lat_start),
        .stop     (lat_stop),
        .shift_en (active & sclk_rise),
        .sdi      (sdi_s),
        .cmd_vld  (cmd_vld),
        .cmd_addr (cmd_addr),
        .cmd_rd   (cmd_rd),
        .cmd_data (cmd_data)
    );

    // register state update
    always_comb begin
        s_d           = s_q;
        s_d.sclk_prev = sclk_s;
        s_d.lat_prev  = lat_s;
        if (cmd_vld) begin
            if (!cmd_rd) begin
                for (int i = 0; i < NUM_CFG; i++) begin
                    if (cmd_addr == ADDR_W'(i)) begin
                        s_d.cfg[i] = cmd_data;
                    end
                end
            end
            s_d.rd_pend = cmd_rd;
            s_d.rd_addr = cmd_addr;
        end else if (lat_start) begin
            s_d.rd_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.lat_prev  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // readback selection
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (s_q.rd_addr == ADDR_W'(i)) begin
                rd_data = s_q.cfg[i];
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (s_q.rd_addr == PEAK_BASE + ADDR_W'(c)) begin
                rd_data = DATA_W'(pk_val[c]);
            end
        end
    end

    always_comb begin
        reply.addr = s_q.rd_addr;
        reply.rd   = 1'b1;
        reply.rsvd = 1'b0;
        reply.data = rd_data;
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            pk_clr[c] = lat_start && s_q.rd_pend &&
                        (s_q.rd_addr == PEAK_BASE + ADDR_W'(c));
        end
    end

    reply_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (lat_start),
        .load     (s_q.rd_pend),
        .word     (reply),
        .shift_en (active & sclk_fall),
        .active   (active),
        .sdo      (sdo_o)
    );

    assign trk_en = s_q.cfg[TRK_REG][TRK_BIT];
    assign pk_smp = {smp_r_i, smp_l_i};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_peak
        peak_track #(
            .W (PEAK_W)
        ) u_peak (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (trk_en),
            .vld   (smp_vld_i),
            .smp   (pk_smp[c]),
            .clr   (pk_clr[c]),
            .peak  (pk_val[c])
        );
    end

    assign cfg0_o = s_q.cfg[0];
    assign cfg1_o = s_q.cfg[1];
    assign cfg2_o = s_q.cfg[2];

endmodule

// File: rtl/ctl_port_regfile_chk.sv
module ctl_port_regfile_chk
    import ctl_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          latch_n_i,
    input  logic                          sdo_o,
    input  logic                          lat_stop,
    input  logic [DATA_W-1:0]             cfg0_o,
    input  logic [DATA_W-1:0]             cfg1_o,
    input  logic [DATA_W-1:0]             cfg2_o,
    input  logic                          trk_en,
    input  logic [NUM_CH-1:0]             pk_clr,
    input  logic [NUM_CH-1:0][PEAK_W-1:0] pk_val
);

    localparam int HW = 8;
    logic [HW-1:0] hi_cnt;

    // consecutive cycles with the latch line high, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!latch_n_i) begin
            hi_cnt <= '0;
        end else if (hi_cnt != {HW{1'b1}}) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    p_sdo_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hi_cnt) >= SYNC_STAGES) |-> !sdo_o);

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_stop |=> $stable({cfg0_o, cfg1_o, cfg2_o}));

    p_peak_grow_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_clr[0] |=> (pk_val[0] >= $past(pk_val[0])));

    p_peak_grow_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_clr[1] |=> (pk_val[1] >= $past(pk_val[1])));

    p_peak_hold_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_en && !pk_clr[0]) |=> $stable(pk_val[0]));

    p_peak_hold_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_en && !pk_clr[1]) |=> $stable(pk_val[1]));

    p_clr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_clr[0] && !trk_en) |=> (pk_val[0] == '0));

endmodule

bind ctl_port_regfile ctl_port_regfile_chk #(
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_n_i (latch_n_i),
    .sdo_o     (sdo_o),
    .lat_stop  (lat_stop),
    .cfg0_o    (cfg0_o),
    .cfg1_o    (cfg1_o),
    .cfg2_o    (cfg2_o),
    .trk_en    (trk_en),
    .pk_clr    (pk_clr),
    .pk_val    (pk_val)
);

// File: tb/ctl_port_regfile_tb.sv
module ctl_port_regfile_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       latch_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       vld = 1'b0;
    logic [5:0] sl = '0;
    logic [5:0] sr = '0;
    logic [9:0] cfg0, cfg1, cfg2;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 0;
    bit done   = 0;

    // reference model state
    logic [9:0] m_cfg [3];
    logic [5:0] m_pk  [2];
    bit         m_clr [2];
    bit         m_pend;
    logic [3:0] m_addr;

    always #5 clk = ~clk;

    ctl_port_regfile u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .latch_n_i (latch_n),
        .sdi_i     (sdi),
        .sdo_o     (sdo),
        .smp_vld_i (vld),
        .smp_l_i   (sl),
        .smp_r_i   (sr),
        .cfg0_o    (cfg0),
        .cfg1_o    (cfg1),
        .cfg2_o    (cfg2)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int a, input bit rd, input int d);
        return {4'(a), rd, 1'b0, 10'(d)};
    endfunction

    function automatic logic [15:0] m_reply();
        logic [9:0] d;
        if (!m_pend) return 16'h0;
        d = '0;
        if (m_addr < 3)       d = m_cfg[m_addr];
        else if (m_addr == 3) d = {4'b0, m_pk[0]};
        else if (m_addr == 4) d = {4'b0, m_pk[1]};
        return {m_addr, 1'b1, 1'b0, d};
    endfunction

    // peak model, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pk[0] = '0;
            m_pk[1] = '0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                logic [5:0] s;
                bit hit;
                s   = (c == 0) ? sl : sr;
                hit = vld && m_cfg[2][0];
                if (m_clr[c]) begin
                    m_pk[c]  = hit ? s : 6'h0;
                    m_clr[c] = 0;
                end else if (hit && s > m_pk[c]) begin
                    m_pk[c] = s;
                end
            end
        end
    end

    // control registers compared every clock (R3)
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cfg0 == m_cfg[0], "R3", "cfg0", cfg0, m_cfg[0]);
            chk(cfg1 == m_cfg[1], "R3", "cfg1", cfg1, m_cfg[1]);
            chk(cfg2 == m_cfg[2], "R3", "cfg2", cfg2, m_cfg[2]);
        end
    end

    task automatic frame(input int nbits, input logic [15:0] w,
                         input string tag = "", input bit coll = 0,
                         input logic [5:0] cl = 0, input logic [5:0] cr = 0);
        logic [15:0] exp;
        string       t;
        @(negedge clk) latch_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        exp = m_reply();
        if (!m_pend)         t = "R8";
        else if (m_addr < 3) t = "R6";
        else                 t = "R7";
        if (tag != "") t = tag;
        if (m_pend && m_addr == 3) m_clr[0] = 1;
        if (m_pend && m_addr == 4) m_clr[1] = 1;
        m_pend = 0;
        if (coll) begin
            vld = 1'b1;
            sl  = cl;
            sr  = cr;
        end
        @(negedge clk) vld = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            logic eb;
            @(negedge clk) sdi = (i < 16) ? w[15-i] : 1'b1;
            repeat (3) @(negedge clk);
            eb = (i < 16) ? exp[15-i] : 1'b0;
            chk(sdo == eb, t, $sformatf("sdo bit %0d", i), sdo, eb);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        latch_n = 1'b1;
        sdi     = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        #1;
        if (nbits == 16) begin
            if (!w[11] && w[15:12] < 3) m_cfg[w[15:12]] = w[9:0];
            m_pend = w[11];
            m_addr = w[15:12];
        end
        repeat (3) @(negedge clk);
        chk(sdo == 1'b0, "R1", "sdo idle after frame", sdo, 0);
    endtask

    task automatic sample(input logic [5:0] l, input logic [5:0] r);
        @(negedge clk);
        vld = 1'b1;
        sl  = l;
        sr  = r;
        @(negedge clk) vld = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) m_cfg[i] = '0;
        m_pk[0] = '0; m_pk[1] = '0;
        m_clr[0] = 0; m_clr[1] = 0;
        m_pend = 0; m_addr = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg0 == 0, "R11", "cfg0 reset", cfg0, 0);
        chk(cfg1 == 0, "R11", "cfg1 reset", cfg1, 0);
        chk(cfg2 == 0, "R11", "cfg2 reset", cfg2, 0);
        chk(sdo == 0,  "R11", "sdo reset",  sdo, 0);
        cmp_on = 1;

        // R3 writes, R2 bit order on readback
        frame(16, mk(0, 0, 10'h2A5));
        frame(16, mk(1, 0, 10'h155));
        frame(16, mk(2, 0, 10'h001));
        frame(16, mk(0, 1, 0));
        frame(16, mk(1, 1, 0), "R2");
        frame(16, mk(2, 1, 0));
        frame(16, mk(0, 0, 10'h2A5));

        // R4 wrong lengths
        frame(15, mk(1, 0, 10'h3FF));
        frame(17, mk(1, 0, 10'h0F0));
        chk(cfg1 == m_cfg[1], "R4", "cfg1 after short/long", cfg1, m_cfg[1]);
        frame(16, mk(0, 1, 0));
        frame(12, mk(2, 1, 0));
        frame(16, mk(5, 0, 0), "R4");

        // R5 writes to peak and unmapped addresses
        frame(16, mk(3, 0, 10'h3FF));
        frame(16, mk(4, 0, 10'h3FF));
        frame(16, mk(9, 0, 10'h3FF));
        frame(16, mk(15, 0, 10'h3FF));
        chk(cfg0 == 10'h2A5, "R5", "cfg0 kept", cfg0, 10'h2A5);
        chk(cfg1 == 10'h155, "R5", "cfg1 kept", cfg1, 10'h155);
        chk(cfg2 == 10'h001, "R5", "cfg2 kept", cfg2, 10'h001);
        frame(16, mk(3, 1, 0));
        frame(16, mk(4, 1, 0), "R5");
        frame(16, mk(7, 1, 0), "R5");
        frame(16, mk(0, 0, 10'h2A5), "R7");

        // R9 tracking enabled
        sample(6'd10, 6'd7);
        sample(6'd5, 6'd20);
        sample(6'd40, 6'd3);
        sample(6'd39, 6'd63);
        frame(16, mk(3, 1, 0));
        frame(16, mk(4, 1, 0), "R9");
        frame(16, mk(3, 1, 0), "R9");
        frame(16, mk(0, 0, 10'h2A5), "R10");

        // R9 tracking disabled
        frame(16, mk(2, 0, 0));
        sample(6'd50, 6'd50);
        frame(16, mk(3, 1, 0));
        frame(16, mk(4, 1, 0), "R9");
        frame(16, mk(2, 0, 10'h001), "R9");

        // R10 sample in the clearing cycle
        sample(6'd30, 6'd12);
        frame(16, mk(3, 1, 0));
        frame(16, mk(4, 1, 0), "R9", 1, 6'd17, 6'd5);
        frame(16, mk(3, 1, 0), "R10");
        frame(16, mk(0, 0, 10'h2A5), "R10");

        // R1 clock activity with latch high
        for (int k = 0; k < 6; k++) begin
            @(negedge clk) sdi = 1'b1;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
            chk(sdo == 1'b0, "R1", "sdo with latch high", sdo, 0);
        end
        sdi = 1'b0;
        chk(cfg1 == m_cfg[1], "R1", "cfg1 with latch high", cfg1, m_cfg[1]);
        frame(16, mk(1, 0, 10'h3C3));
        frame(16, mk(1, 1, 0));
        frame(16, mk(0, 0, 10'h2A5), "R1");

        repeat (5) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule